// File: doc/BRIEF.md
# Queued Chunked DMA Command Engine

This block is a DMA engine fed by a small in-order command queue. Software loads four parameter registers through a simple write port: source address, destination address, source length and destination length. The write that lands on the destination length register turns the four values into one queued command. The lengths are counted in 32-bit words, and the addresses are forced to word alignment when the command is taken.

A single state machine takes the oldest queued command and breaks it into chunks of at most 1024 bytes. For each chunk it issues one read request, with address and byte count, on a ready/valid handshake and then waits for a completion pulse from memory. When the loopback input is set, each chunk that was read is then written back through a matching write request and completion. The chunk size is limited by the remaining source bytes, and in loopback mode also by the remaining destination bytes. When no further chunk can be formed, the command is retired. The engine then raises a one-cycle done pulse and a partial-done pulse, removes the entry from the queue and moves on to the next command.

A status word reports queue-full, queue-empty and a saturating count of completed commands. An enqueue that arrives while the queue is full is dropped and produces a one-cycle overflow pulse.

Top module: `dmaq_engine`

States of the transfer machine: S_IDLE (queue empty, waiting), S_LOAD (copy the head entry into working registers), S_EVAL (size the next chunk), S_RD_REQ (present the read request), S_RD_WAIT (wait for the read completion), S_WR_REQ (present the loopback write request), S_WR_WAIT (wait for the write completion), S_DONE (retire the command). The transitions are:
- S_IDLE→S_LOAD when the queue is not empty.
- S_LOAD→S_EVAL unconditionally.
- S_EVAL→S_DONE when the chunk size is zero; otherwise S_EVAL→S_RD_REQ.
- S_RD_REQ→S_RD_WAIT when the read is accepted.
- S_RD_WAIT→S_WR_REQ on completion in loopback mode; otherwise S_RD_WAIT→S_EVAL on completion.
- S_WR_REQ→S_WR_WAIT when the write is accepted.
- S_WR_WAIT→S_EVAL on the write completion.
- S_DONE→S_IDLE unconditionally.

## Requirements
- R1: A write with `cfg_sel`=3 (destination length) enqueues one command built from the current source address (`cfg_sel`=0), destination address (`cfg_sel`=1) and source length (`cfg_sel`=2) registers, together with the data of that write. Both addresses have bits 1:0 cleared.
- R2: Length values count 32-bit words. Only `cfg_data` bits 26:0 are kept, and the byte length is that value shifted left by two.
- R3: Every read request carries a byte count of 1 to 1024. That count equals the smaller of 1024 and the remaining source bytes, and the read address advances by the count after each chunk.
- R4: With `loop_en` set, the chunk is also limited by the remaining destination bytes. Each chunk read is followed by a write request of the same byte count at the current destination address, and that address then advances.
- R5: With `loop_en` clear, no write request is made and the destination length has no effect.
- R6: When no nonzero chunk remains, `done_o` and `part_done_o` pulse together for exactly one cycle and the command leaves the queue. A zero-size command is retired without any request.
- R7: Commands are executed strictly in enqueue order until the queue is empty.
- R8: `status_o` bit 30 is queue-empty and is set after reset. Bit 31 is queue-full and is set when 4 commands are held, counting the one in progress.
- R9: An enqueue while the queue is full is dropped, and `ovf_o` pulses for one cycle in the cycle after that write.
- R10: `status_o` bits 29:28 count retired commands, starting at 0 after reset and saturating at 3. All other status bits read 0.
- R11: While a read or write request is valid and not accepted, it stays valid and its address and byte count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Parameter register write strobe |
| cfg_sel | input | 2 | Register select: 0 src addr, 1 dst addr, 2 src len, 3 dst len (enqueues) |
| cfg_data | input | 32 | Write data |
| loop_en | input | 1 | Loopback: write each chunk read to the destination |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read chunk byte address |
| rd_req_bytes | output | 11 | Read chunk byte count |
| rd_cpl | input | 1 | Read chunk completed |
| wr_req_valid | output | 1 | Write request valid |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | 32 | Write chunk byte address |
| wr_req_bytes | output | 11 | Write chunk byte count |
| wr_cpl | input | 1 | Write chunk completed |
| done_o | output | 1 | Command done pulse |
| part_done_o | output | 1 | Partial done pulse, same cycle as done |
| ovf_o | output | 1 | Queue overflow pulse |
| status_o | output | 32 | {full, empty, done count[1:0], 28'b0} |

## Verification
On every cycle the assertions check these properties: the chunk bound on read requests, that stalled requests stay stable, that the done pulse lasts one cycle, that full and empty are never set together, that a dropped enqueue leaves the queue count unchanged, and that the done counter stays at 3 once it saturates. Other properties need the bench's scenarios and its reference model of the queue, which follows each command's remaining bytes. These are the exact chunk sequence and addresses, the alignment and masking of captured values, the loopback write stream, the absence of writes without loopback, retirement of zero-size and mismatched-length commands, and the overflow drop when the memory is stalled.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_EVAL,
        S_RD_REQ,
        S_RD_WAIT,
        S_WR_REQ,
        S_WR_WAIT,
        S_DONE
    } xfer_state_t;

    localparam logic [1:0] SEL_SRC_ADDR = 2'd0;
    localparam logic [1:0] SEL_DST_ADDR = 2'd1;
    localparam logic [1:0] SEL_SRC_LEN  = 2'd2;
    localparam logic [1:0] SEL_DST_LEN  = 2'd3;

endpackage

// File: rtl/dmaq_cmd_fifo.sv
module dmaq_cmd_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAPAC = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CAPAC);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    // R9: a push into a full queue leaves the occupancy untouched
    p_drop_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (full && $stable(count)));

endmodule

// File: rtl/dmaq_chunk_sizer.sv
module dmaq_chunk_sizer #(
    parameter int BYTE_W    = 29,
    parameter int CHUNK_MAX = 1024,
    parameter int CHUNK_W   = 11
) (
    input  logic [BYTE_W-1:0]  src_rem,
    input  logic [BYTE_W-1:0]  dst_rem,
    input  logic               use_dst,
    output logic [CHUNK_W-1:0] chunk
);
    localparam logic [BYTE_W-1:0]  CAP_B = BYTE_W'(CHUNK_MAX);
    localparam logic [CHUNK_W-1:0] CAP_C = CHUNK_W'(CHUNK_MAX);

    logic [CHUNK_W-1:0] src_c, dst_c;

    always_comb begin
        src_c = (src_rem < CAP_B) ? src_rem[CHUNK_W-1:0] : CAP_C;
        dst_c = (dst_rem < CAP_B) ? dst_rem[CHUNK_W-1:0] : CAP_C;
        if (use_dst && (dst_c < src_c)) begin
            chunk = dst_c;
        end else begin
            chunk = src_c;
        end
    end

endmodule

// File: rtl/dmaq_xfer_fsm.sv
module dmaq_xfer_fsm
    import dmaq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BYTE_W    = 29,
    parameter int CHUNK_MAX = 1024,
    parameter int CHUNK_W   = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q_empty,
    input  logic [ADDR_W-1:0]  h_src_addr,
    input  logic [ADDR_W-1:0]  h_dst_addr,
    input  logic [BYTE_W-1:0]  h_src_bytes,
    input  logic [BYTE_W-1:0]  h_dst_bytes,
    input  logic               loop_en,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [ADDR_W-1:0]  rd_req_addr,
    output logic [CHUNK_W-1:0] rd_req_bytes,
    input  logic               rd_cpl,
    output logic               wr_req_valid,
    input  logic               wr_req_ready,
    output logic [ADDR_W-1:0]  wr_req_addr,
    output logic [CHUNK_W-1:0] wr_req_bytes,
    input  logic               wr_cpl,
    output logic               q_pop,
    output logic               done_pulse
);
    localparam logic [CHUNK_W-1:0] CAP_C = CHUNK_W'(CHUNK_MAX);

    xfer_state_t state, state_nx;

    logic [ADDR_W-1:0]  w_src_addr, w_dst_addr;
    logic [BYTE_W-1:0]  w_src_rem, w_dst_rem;
    logic               loop_q;
    logic [CHUNK_W-1:0] chunk_q, chunk_now;
    logic [BYTE_W-1:0]  chunk_ext;

    assign chunk_ext = BYTE_W'(chunk_q);

    dmaq_chunk_sizer #(
        .BYTE_W   (BYTE_W),
        .CHUNK_MAX(CHUNK_MAX),
        .CHUNK_W  (CHUNK_W)
    ) i_sizer (
        .src_rem(w_src_rem),
        .dst_rem(w_dst_rem),
        .use_dst(loop_q),
        .chunk  (chunk_now)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (!q_empty) state_nx = S_LOAD;
            S_LOAD:    state_nx = S_EVAL;
            S_EVAL:    state_nx = (chunk_now == '0) ? S_DONE : S_RD_REQ;
            S_RD_REQ:  if (rd_req_ready) state_nx = S_RD_WAIT;
            S_RD_WAIT: if (rd_cpl) state_nx = loop_q ? S_WR_REQ : S_EVAL;
            S_WR_REQ:  if (wr_req_ready) state_nx = S_WR_WAIT;
            S_WR_WAIT: if (wr_cpl) state_nx = S_EVAL;
            S_DONE:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_req_valid = 1'b0;
        wr_req_valid = 1'b0;
        q_pop        = 1'b0;
        done_pulse   = 1'b0;
        unique case (state)
            S_RD_REQ: rd_req_valid = 1'b1;
            S_WR_REQ: wr_req_valid = 1'b1;
            S_DONE: begin
                q_pop      = 1'b1;
                done_pulse = 1'b1;
            end
            default: ;
        endcase
    end

    assign rd_req_addr  = w_src_addr;
    assign rd_req_bytes = chunk_q;
    assign wr_req_addr  = w_dst_addr;
    assign wr_req_bytes = chunk_q;

    // working registers of the active command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_src_addr <= '0;
            w_dst_addr <= '0;
            w_src_rem  <= '0;
            w_dst_rem  <= '0;
            loop_q     <= 1'b0;
            chunk_q    <= '0;
        end else begin
            if (state == S_LOAD) begin
                w_src_addr <= h_src_addr;
                w_dst_addr <= h_dst_addr;
                w_src_rem  <= h_src_bytes;
                w_dst_rem  <= h_dst_bytes;
                loop_q     <= loop_en;
            end
            if (state == S_EVAL) begin
                chunk_q <= chunk_now;
            end
            if (state == S_RD_WAIT && rd_cpl) begin
                w_src_addr <= w_src_addr + ADDR_W'(chunk_q);
                w_src_rem  <= w_src_rem - chunk_ext;
            end
            if (state == S_WR_WAIT && wr_cpl) begin
                w_dst_addr <= w_dst_addr + ADDR_W'(chunk_q);
                w_dst_rem  <= w_dst_rem - chunk_ext;
            end
        end
    end

    // R3: read requests never carry an empty or oversized chunk
    p_chunk_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_bytes != '0 && rd_req_bytes <= CAP_C));

    // R11: a stalled read request holds its payload
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=>
            (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_bytes)));

    // R11: a stalled write request holds its payload
    p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_valid && !wr_req_ready) |=>
            (wr_req_valid && $stable(wr_req_addr) && $stable(wr_req_bytes)));

    // R6: completion is a single-cycle pulse
    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

endmodule

// File: rtl/dmaq_engine.sv
module dmaq_engine
    import dmaq_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int LEN_W     = 27,
    parameter int DEPTH     = 4,
    parameter int CHUNK_MAX = 1024,
    parameter int CNT_W     = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [1:0]                     cfg_sel,
    input  logic [WORD_W-1:0]              cfg_data,
    input  logic                           loop_en,
    output logic                           rd_req_valid,
    input  logic                           rd_req_ready,
    output logic [WORD_W-1:0]              rd_req_addr,
    output logic [$clog2(CHUNK_MAX):0]     rd_req_bytes,
    input  logic                           rd_cpl,
    output logic                           wr_req_valid,
    input  logic                           wr_req_ready,
    output logic [WORD_W-1:0]              wr_req_addr,
    output logic [$clog2(CHUNK_MAX):0]     wr_req_bytes,
    input  logic                           wr_cpl,
    output logic                           done_o,
    output logic                           part_done_o,
    output logic                           ovf_o,
    output logic [WORD_W-1:0]              status_o
);
    localparam int BYTE_W  = LEN_W + 2;
    localparam int CHUNK_W = $clog2(CHUNK_MAX) + 1;
    localparam int ENT_W   = 2 * WORD_W + 2 * BYTE_W;
    localparam int PAD_W   = WORD_W - 2 - CNT_W;
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [WORD_W-1:0] src_addr_r, dst_addr_r;
    logic [LEN_W-1:0]  src_len_r;
    logic [ENT_W-1:0]  ent_in, ent_head;
    logic              enq, q_pop, q_full, q_empty, done_pulse;
    logic [CNT_W-1:0]  done_cnt;
    logic              ovf_q;

    logic [WORD_W-1:0] h_src_addr, h_dst_addr;
    logic [BYTE_W-1:0] h_src_bytes, h_dst_bytes;

    assign enq = cfg_we && (cfg_sel == SEL_DST_LEN);

    // parameter registers; addresses are aligned when written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr_r <= '0;
            dst_addr_r <= '0;
            src_len_r  <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_SRC_ADDR: src_addr_r <= {cfg_data[WORD_W-1:2], 2'b00};
                SEL_DST_ADDR: dst_addr_r <= {cfg_data[WORD_W-1:2], 2'b00};
                SEL_SRC_LEN:  src_len_r  <= cfg_data[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    assign ent_in = {src_addr_r, dst_addr_r,
                     src_len_r, 2'b00, cfg_data[LEN_W-1:0], 2'b00};
    assign {h_src_addr, h_dst_addr, h_src_bytes, h_dst_bytes} = ent_head;

    dmaq_cmd_fifo #(
        .WIDTH(ENT_W),
        .DEPTH(DEPTH)
    ) i_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (enq),
        .push_data(ent_in),
        .pop      (q_pop),
        .head     (ent_head),
        .full     (q_full),
        .empty    (q_empty)
    );

    dmaq_xfer_fsm #(
        .ADDR_W   (WORD_W),
        .BYTE_W   (BYTE_W),
        .CHUNK_MAX(CHUNK_MAX),
        .CHUNK_W  (CHUNK_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_empty     (q_empty),
        .h_src_addr  (h_src_addr),
        .h_dst_addr  (h_dst_addr),
        .h_src_bytes (h_src_bytes),
        .h_dst_bytes (h_dst_bytes),
        .loop_en     (loop_en),
        .rd_req_valid(rd_req_valid),
        .rd_req_ready(rd_req_ready),
        .rd_req_addr (rd_req_addr),
        .rd_req_bytes(rd_req_bytes),
        .rd_cpl      (rd_cpl),
        .wr_req_valid(wr_req_valid),
        .wr_req_ready(wr_req_ready),
        .wr_req_addr (wr_req_addr),
        .wr_req_bytes(wr_req_bytes),
        .wr_cpl      (wr_cpl),
        .q_pop       (q_pop),
        .done_pulse  (done_pulse)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_cnt <= '0;
            ovf_q    <= 1'b0;
        end else begin
            ovf_q <= enq && q_full;
            if (done_pulse && done_cnt != CNT_TOP) begin
                done_cnt <= done_cnt + 1'b1;
            end
        end
    end

    assign done_o      = done_pulse;
    assign part_done_o = done_pulse;
    assign ovf_o       = ovf_q;
    assign status_o    = {q_full, q_empty, done_cnt, {PAD_W{1'b0}}};

    // R8: the queue is never reported both full and empty
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[WORD_W-1] && status_o[WORD_W-2]));

    // R10: the done counter holds once saturated
    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_cnt == CNT_TOP) |=> (done_cnt == CNT_TOP));

endmodule

// File: tb/test_dmaq_engine.sv
module test_dmaq_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_data = '0;
    logic        loop_en = 1'b0;
    logic        rd_req_valid, wr_req_valid;
    logic        rd_req_ready = 1'b0, wr_req_ready = 1'b0;
    logic [31:0] rd_req_addr, wr_req_addr;
    logic [10:0] rd_req_bytes, wr_req_bytes;
    logic        rd_cpl = 1'b0, wr_cpl = 1'b0;
    logic        done_o, part_done_o, ovf_o;
    logic [31:0] status_o;

    always #2 clk = ~clk; // 250 MHz

    dmaq_engine i_dmaq_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .loop_en(loop_en),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_bytes(rd_req_bytes), .rd_cpl(rd_cpl),
        .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
        .wr_req_addr(wr_req_addr), .wr_req_bytes(wr_req_bytes), .wr_cpl(wr_cpl),
        .done_o(done_o), .part_done_o(part_done_o), .ovf_o(ovf_o),
        .status_o(status_o)
    );

    int compared = 0;
    int mismatched = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model state
    int unsigned mq_sa[$], mq_da[$], mq_sr[$], mq_dr[$];
    bit          mq_lp[$];
    int unsigned pw_addr[$], pw_bytes[$];
    int unsigned m_src_addr = 0, m_dst_addr = 0, m_src_len = 0;
    int unsigned m_cnt = 0;
    bit          exp_ovf = 1'b0;
    bit          prev_rd_stall = 1'b0, prev_wr_stall = 1'b0;
    logic [31:0] prev_rd_addr, prev_wr_addr;
    logic [10:0] prev_rd_bytes, prev_wr_bytes;

    // memory stub state
    bit stall = 1'b0;
    bit rd_start = 1'b0, wr_start = 1'b0;
    int rd_dly = 0, wr_dly = 0;

    function automatic int unsigned next_chunk(input int unsigned s, input int unsigned d,
                                               input bit lp);
        int unsigned c;
        c = (s < 1024) ? s : 1024;
        if (lp && d < c) c = d;
        return c;
    endfunction

    // per-cycle comparison against the model, then event prediction
    always @(negedge clk) begin
        if (rst_n) begin
            int unsigned qs;
            logic [31:0] exp_st;
            qs = mq_sa.size();
            exp_st = {(qs == 4), (qs == 0), m_cnt[1:0], 28'h0};
            chk(status_o[31:30] == exp_st[31:30], "R8 queue flags", status_o, exp_st);
            chk(status_o[29:0] == exp_st[29:0], "R10 done count / zero bits", status_o, exp_st);
            chk(ovf_o == exp_ovf, "R9 overflow pulse", ovf_o, exp_ovf);
            exp_ovf = 1'b0;
            chk(done_o == part_done_o, "R6 done pair", part_done_o, done_o);
            if (prev_rd_stall)
                chk(rd_req_valid && rd_req_addr == prev_rd_addr && rd_req_bytes == prev_rd_bytes,
                    "R11 read hold", {rd_req_valid, rd_req_addr}, {1'b1, prev_rd_addr});
            if (prev_wr_stall)
                chk(wr_req_valid && wr_req_addr == prev_wr_addr && wr_req_bytes == prev_wr_bytes,
                    "R11 write hold", {wr_req_valid, wr_req_addr}, {1'b1, prev_wr_addr});
            prev_rd_stall = rd_req_valid && !rd_req_ready;
            prev_wr_stall = wr_req_valid && !wr_req_ready;
            prev_rd_addr = rd_req_addr; prev_rd_bytes = rd_req_bytes;
            prev_wr_addr = wr_req_addr; prev_wr_bytes = wr_req_bytes;

            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_src_addr = cfg_data & 32'hFFFF_FFFC;
                    2'd1: m_dst_addr = cfg_data & 32'hFFFF_FFFC;
                    2'd2: m_src_len = cfg_data & 32'h07FF_FFFF;
                    default: begin
                        if (qs == 4) exp_ovf = 1'b1;
                        else begin
                            mq_sa.push_back(m_src_addr);
                            mq_da.push_back(m_dst_addr);
                            mq_sr.push_back(m_src_len << 2);
                            mq_dr.push_back((cfg_data & 32'h07FF_FFFF) << 2);
                            mq_lp.push_back(loop_en);
                        end
                    end
                endcase
            end
            if (rd_req_valid && rd_req_ready) begin
                rd_start = 1'b1;
                if (qs == 0) chk(1'b0, "R7 read with empty queue", rd_req_addr, 0);
                else begin
                    int unsigned b;
                    b = next_chunk(mq_sr[0], mq_dr[0], mq_lp[0]);
                    chk(rd_req_addr == mq_sa[0], "R1/R7 read address", rd_req_addr, mq_sa[0]);
                    chk(rd_req_bytes == b, "R2/R3/R4 read chunk", rd_req_bytes, b);
                    mq_sa[0] += b;
                    mq_sr[0] -= b;
                    if (mq_lp[0]) begin
                        pw_addr.push_back(mq_da[0]);
                        pw_bytes.push_back(b);
                        mq_da[0] += b;
                        mq_dr[0] -= b;
                    end
                end
            end
            if (wr_req_valid && wr_req_ready) begin
                wr_start = 1'b1;
                if (pw_addr.size() == 0) chk(1'b0, "R5 unexpected write", wr_req_addr, 0);
                else begin
                    chk(wr_req_addr == pw_addr[0], "R4 write address", wr_req_addr, pw_addr[0]);
                    chk(wr_req_bytes == pw_bytes[0], "R4 write chunk", wr_req_bytes, pw_bytes[0]);
                    void'(pw_addr.pop_front());
                    void'(pw_bytes.pop_front());
                end
            end
            if (done_o) begin
                if (qs == 0) chk(1'b0, "R6 done with empty queue", 1, 0);
                else begin
                    int unsigned r;
                    r = next_chunk(mq_sr[0], mq_dr[0], mq_lp[0]);
                    chk(r == 0 && pw_addr.size() == 0, "R6 retire point", r, 0);
                    void'(mq_sa.pop_front()); void'(mq_da.pop_front());
                    void'(mq_sr.pop_front()); void'(mq_dr.pop_front());
                    void'(mq_lp.pop_front());
                    if (m_cnt < 3) m_cnt++;
                end
            end
        end
    end

    // memory stub
    initial begin
        forever begin
            @(posedge clk);
            #1;
            rd_cpl = 1'b0;
            wr_cpl = 1'b0;
            if (rd_start) begin rd_start = 1'b0; rd_dly = 1 + int'($urandom % 3); end
            else if (rd_dly > 0) begin rd_dly--; if (rd_dly == 0) rd_cpl = 1'b1; end
            if (wr_start) begin wr_start = 1'b0; wr_dly = 1 + int'($urandom % 3); end
            else if (wr_dly > 0) begin wr_dly--; if (wr_dly == 0) wr_cpl = 1'b1; end
            rd_req_ready = !stall && ($urandom % 4 != 0);
            wr_req_ready = !stall && ($urandom % 4 != 0);
        end
    end

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] sa, input logic [31:0] da,
                        input logic [31:0] sl, input logic [31:0] dl);
        wr_reg(2'd0, sa);
        wr_reg(2'd1, da);
        wr_reg(2'd2, sl);
        wr_reg(2'd3, dl);
    endtask

    task automatic drain();
        int guard = 0;
        while ((mq_sa.size() != 0 || status_o[30] != 1'b1) && guard < 20000) begin
            @(posedge clk); #1;
            guard++;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(status_o == 32'h4000_0000, "R8 reset status", status_o, 32'h4000_0000);
        chk(!rd_req_valid && !wr_req_valid && !done_o, "R6 idle after reset",
            {rd_req_valid, wr_req_valid, done_o}, 0);
        @(posedge clk); #1;

        // R1 R5: unaligned addresses, no loopback, destination length ignored
        loop_en = 1'b0;
        send(32'h0000_1003, 32'h0000_2002, 32'd16, 32'd5);
        drain();
        // R3: multi-chunk source
        send(32'h0001_0000, 32'h0002_0000, 32'd700, 32'd0);
        drain();
        // R4: loopback, equal lengths
        loop_en = 1'b1;
        send(32'h0000_4000, 32'h0000_8001, 32'd300, 32'd300);
        drain();
        // R4 R6: loopback, destination shorter than source
        send(32'h0000_5000, 32'h0000_9000, 32'd100, 32'd30);
        drain();
        // R6: zero chunk in loopback
        send(32'h0000_6000, 32'h0000_A000, 32'd10, 32'd0);
        drain();
        // R6: zero-length without loopback
        loop_en = 1'b0;
        send(32'h0000_7000, 32'h0000_B000, 32'd0, 32'd9);
        drain();
        // R2: length bits above 26 dropped
        send(32'h0000_C000, 32'h0000_D000, 32'hF800_0008, 32'hFFFF_FFFF);
        drain();
        // R9 R8 R7: fill with memory stalled, fifth enqueue dropped
        stall = 1'b1;
        for (int k = 0; k < 5; k++) begin
            send(32'h0010_0000 + 32'(k) * 32'h100, 32'h0020_0000, 32'(4 + k), 32'd0);
        end
        @(negedge clk);
        chk(status_o[31] == 1'b1, "R8 full with four held", status_o, 32'h8000_0000);
        @(posedge clk); #1;
        stall = 1'b0;
        drain();
        chk(status_o[29:28] == 2'd3, "R10 saturated count", status_o[29:28], 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL R7 watchdog: queue never drained actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule